// File: doc/BRIEF.md
# PLL Programming Register Interlock

This block holds the programming state of a clock-multiplying PLL and enforces the rules that keep that state consistent. A small synchronous register bus gives software access to two registers. The control register holds a PLL-on bit and a clock-select bit that picks the VCO clock as the base clock. The programming register holds a 4-bit multiplier code and a 4-bit range code. The block drives the effective multiplier N, the range value L, a PLL-enable level and the clock-select level toward the analog PLL and the clock mux.

Three interlocks apply. The programming fields are frozen while the PLL-on bit is set. A multiplier code of zero is treated as one. A range code of zero disables the PLL and keeps the VCO clock from being selected.

Top module: `pll_prog_interlock`

## Requirements
- R1: The output mult_n equals the stored 4-bit multiplier code, except that code 0 gives mult_n = 1.
- R2: A write to the programming register while the stored PLL-on bit is 1 leaves the multiplier code unchanged.
- R3: A write to the programming register while the stored PLL-on bit is 1 leaves the range code unchanged.
- R4: After reset the range code is 6, the multiplier code is 1, and the PLL-on and clock-select bits are 0.
- R5: A write that sets the range code to 0 clears the clock-select bit in the same clock edge, and clk_sel is never 1 while the range code is 0.
- R6: A control write with bit 4 set while the range code is 0 leaves clock-select at 0.
- R7: pll_enable is 1 exactly when the PLL-on bit is 1 and the range code is non-zero.
- R8: Address 0 is the control register (PLL-on at bit 5, clock-select at bit 4), address 1 is the programming register (multiplier at bits 7:4, range at bits 3:0); every other bit and every other address reads 0, and writes to other addresses change nothing.
- R9: The protection decision uses the PLL-on value stored before the write edge: a programming write in the cycle after PLL-on is cleared is accepted, and one in the cycle after it is set is refused.
- R10: bus_rdata presents, one clock after the address is applied, the register contents as they stood before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| mult_n | output | 4 | Effective multiplier N |
| range_l | output | 4 | Range value L |
| pll_enable | output | 1 | PLL running level |
| clk_sel | output | 1 | VCO clock selected as base clock |

## Verification
Field outputs (mult_n, range_l, pll_enable, clk_sel) change on the same edge that takes a write, so the bench updates its model when it drives a write and compares these outputs at the falling edge after that rising edge. Read data is due one edge after the address, and is computed from the model as it stood before the write of that same cycle, so each step captures the expected read value before applying the model update. Random traffic is biased toward range code 0 and the PLL-on bit so that the interlocks are hit often, and directed steps cover the reset values, code 0 of the multiplier, and the on/off turn-around cycles.

// File: rtl/pll_prog_pkg.sv
package pll_prog_pkg;
  localparam int unsigned BUS_W   = 8;
  localparam int unsigned FIELD_W = 4;
  localparam int unsigned ADDR_W  = 2;

  // Address map
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PROG = 2'd1;

  // Control register bit positions
  localparam int unsigned BIT_ON  = 5;
  localparam int unsigned BIT_SEL = 4;

  // Multiplier code to effective N: zero is promoted to one
  function automatic logic [FIELD_W-1:0] eff_mult(input logic [FIELD_W-1:0] code);
    return (code == '0) ? FIELD_W'(1) : code;
  endfunction

  function automatic logic range_live(input logic [FIELD_W-1:0] code);
    return |code;
  endfunction
endpackage

// File: rtl/pll_prog_reg.sv
module pll_prog_reg
  import pll_prog_pkg::*;
#(
  parameter int unsigned FW        = FIELD_W,
  parameter logic [FW-1:0] MULT_RST  = 4'd1,
  parameter logic [FW-1:0] RANGE_RST = 4'd6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic          pll_on_q,
  input  logic [FW-1:0] wd_mult,
  input  logic [FW-1:0] wd_range,
  output logic [FW-1:0] mult_q,
  output logic [FW-1:0] range_q,
  output logic [FW-1:0] range_next,
  output logic          wr_ok
);
  // Protection looks at the stored PLL-on bit, i.e. the value before this edge
  assign wr_ok      = wr_req && !pll_on_q;
  assign range_next = wr_ok ? wd_range : range_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mult_q  <= MULT_RST;
      range_q <= RANGE_RST;
    end else if (wr_ok) begin
      mult_q  <= wd_mult;
      range_q <= wd_range;
    end
  end

  a_r2_mult_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && pll_on_q) |=> $stable(mult_q));
  a_r3_range_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && pll_on_q) |=> $stable(range_q));
endmodule

// File: rtl/pll_ctrl_reg.sv
module pll_ctrl_reg
  import pll_prog_pkg::*;
#(
  parameter int unsigned FW = FIELD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic          wd_on,
  input  logic          wd_sel,
  input  logic [FW-1:0] range_next,
  output logic          pll_on_q,
  output logic          clk_sel_q,
  output logic          sel_blocked
);
  logic sel_cand;
  logic sel_d;

  assign sel_cand    = wr_req ? wd_sel : clk_sel_q;
  assign sel_blocked = sel_cand && !range_live(range_next);
  assign sel_d       = sel_cand && !sel_blocked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pll_on_q  <= 1'b0;
      clk_sel_q <= 1'b0;
    end else begin
      if (wr_req) pll_on_q <= wd_on;
      clk_sel_q <= sel_d;
    end
  end

  a_r6_sel_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wd_sel && !range_live(range_next)) |=> !clk_sel_q);
endmodule

// File: rtl/pll_rd_mux.sv
module pll_rd_mux
  import pll_prog_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = BUS_W,
  parameter int unsigned FW = FIELD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          pll_on_q,
  input  logic          clk_sel_q,
  input  logic [FW-1:0] mult_q,
  input  logic [FW-1:0] range_q,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] rd_d;

  always_comb begin
    rd_d = '0;
    unique case (addr)
      ADDR_CTRL: begin
        rd_d[BIT_ON]  = pll_on_q;
        rd_d[BIT_SEL] = clk_sel_q;
      end
      ADDR_PROG: rd_d = {mult_q, range_q};
      default:   rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_d;
  end
endmodule

// File: rtl/pll_prog_interlock.sv
module pll_prog_interlock
  import pll_prog_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  output logic [FIELD_W-1:0] mult_n,
  output logic [FIELD_W-1:0] range_l,
  output logic               pll_enable,
  output logic               clk_sel
);
  localparam int unsigned FW = FIELD_W;

  // Named internal events
  logic          ctrl_wr;
  logic          prog_wr;
  logic          prog_wr_ok;
  logic          sel_blocked;
  logic          pll_on_q;
  logic          clk_sel_q;
  logic [FW-1:0] mult_q;
  logic [FW-1:0] range_q;
  logic [FW-1:0] range_next;

  assign ctrl_wr = bus_we && (bus_addr == ADDR_CTRL);
  assign prog_wr = bus_we && (bus_addr == ADDR_PROG);

  pll_ctrl_reg #(.FW(FW)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_req     (ctrl_wr),
    .wd_on      (bus_wdata[BIT_ON]),
    .wd_sel     (bus_wdata[BIT_SEL]),
    .range_next (range_next),
    .pll_on_q   (pll_on_q),
    .clk_sel_q  (clk_sel_q),
    .sel_blocked(sel_blocked)
  );

  pll_prog_reg #(.FW(FW)) prog_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_req    (prog_wr),
    .pll_on_q  (pll_on_q),
    .wd_mult   (bus_wdata[2*FW-1:FW]),
    .wd_range  (bus_wdata[FW-1:0]),
    .mult_q    (mult_q),
    .range_q   (range_q),
    .range_next(range_next),
    .wr_ok     (prog_wr_ok)
  );

  pll_rd_mux #(.AW(ADDR_W), .DW(BUS_W), .FW(FW)) rd_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (bus_addr),
    .pll_on_q (pll_on_q),
    .clk_sel_q(clk_sel_q),
    .mult_q   (mult_q),
    .range_q  (range_q),
    .rdata    (bus_rdata)
  );

  assign mult_n     = eff_mult(mult_q);
  assign range_l    = range_q;
  assign pll_enable = pll_on_q && range_live(range_q);
  assign clk_sel    = clk_sel_q;

  a_r1_n_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    mult_n != '0);
  a_r5_sel_needs_range: assert property (@(posedge clk) disable iff (!rst_n)
    (range_l == '0) |-> !clk_sel);
  a_r7_enable_needs_range: assert property (@(posedge clk) disable iff (!rst_n)
    (range_l == '0) |-> !pll_enable);
  a_r9_on_then_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && bus_wdata[BIT_ON]) |=> (prog_wr -> !prog_wr_ok));
  a_r10_prog_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_PROG) |=> (bus_rdata == {$past(mult_q), $past(range_q)}));
  a_r8_bad_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > ADDR_PROG) |=> (bus_rdata == '0));
endmodule

// File: tb/pll_prog_interlock_tb_top.sv
`timescale 1ns/1ps
module pll_prog_interlock_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] mult_n;
  logic [3:0] range_l;
  logic       pll_enable;
  logic       clk_sel;

  always #2 clk = ~clk;  // 250 MHz

  pll_prog_interlock dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mult_n(mult_n),
    .range_l(range_l), .pll_enable(pll_enable), .clk_sel(clk_sel)
  );

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit done = 1'b0;

  // Bench model of the stored state
  logic [3:0] m_mult, m_range;
  logic       m_on, m_sel;

  function automatic logic [3:0] exp_n(input logic [3:0] c);
    if (c == 4'd0) return 4'd1;
    return c;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0:    return {2'b00, m_on, m_sel, 4'b0000};
      2'd1:    return {m_mult, m_range};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_outs();
    check("R1 mult_n", {4'h0, mult_n}, {4'h0, exp_n(m_mult)});
    check("R3 range_l", {4'h0, range_l}, {4'h0, m_range});
    check("R7 pll_enable", {7'h0, pll_enable}, {7'h0, m_on && (m_range != 0)});
    check("R5 clk_sel", {7'h0, clk_sel}, {7'h0, m_sel});
  endtask

  // One bus cycle: drive at falling edge, check after the following rising edge
  task automatic step(input logic [1:0] a, input logic we, input logic [7:0] wd);
    logic [7:0] rd_exp;
    bus_addr = a; bus_we = we; bus_wdata = wd;
    rd_exp = exp_rd(a);
    if (we && a == 2'd0) begin
      m_on  = wd[5];
      m_sel = wd[4] && (m_range != 0);
    end else if (we && a == 2'd1 && !m_on) begin
      m_mult  = wd[7:4];
      m_range = wd[3:0];
      if (m_range == 0) m_sel = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    check("R10 rdata", bus_rdata, rd_exp);
    check_outs();
  endtask

  initial begin
    m_mult = 4'd1; m_range = 4'd6; m_on = 1'b0; m_sel = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R4 reset values
    check("R4 mult_n", {4'h0, mult_n}, 8'h01);
    check("R4 range_l", {4'h0, range_l}, 8'h06);
    check("R4 enable/sel", {6'h0, pll_enable, clk_sel}, 8'h00);
    step(2'd1, 1'b0, 8'h00);
    step(2'd1, 1'b0, 8'h00);  // R8 programming readback 0x16
    check("R4 R8 prog read", bus_rdata, 8'h16);
    step(2'd0, 1'b0, 8'h00);
    step(2'd0, 1'b0, 8'h00);
    check("R4 R8 ctrl read", bus_rdata, 8'h00);
    // R1 code 0 gives N=1
    step(2'd1, 1'b1, 8'h03);
    check("R1 zero code", {4'h0, mult_n}, 8'h01);
    step(2'd1, 1'b1, 8'hF5);
    check("R1 code 15", {4'h0, mult_n}, 8'h0F);
    // R9 turn on, then immediate write refused
    step(2'd0, 1'b1, 8'h30);
    step(2'd1, 1'b1, 8'h28);
    check("R2 R9 frozen mult", {4'h0, mult_n}, 8'h0F);
    check("R3 frozen range", {4'h0, range_l}, 8'h05);
    // R9 turn off, next write accepted
    step(2'd0, 1'b1, 8'h10);
    step(2'd1, 1'b1, 8'h28);
    check("R9 accepted", {mult_n, range_l}, 8'h28);
    // R5 range to zero clears select
    step(2'd1, 1'b1, 8'h40);
    check("R5 sel cleared", {7'h0, clk_sel}, 8'h00);
    // R6 set select with range zero refused
    step(2'd0, 1'b1, 8'h10);
    check("R6 sel refused", {7'h0, clk_sel}, 8'h00);
    // R7 on with range zero: enable low
    step(2'd0, 1'b1, 8'h20);
    check("R7 enable low", {7'h0, pll_enable}, 8'h00);
    step(2'd0, 1'b1, 8'h00);
    // R8 other address: write ignored, reads zero
    step(2'd2, 1'b1, 8'hFF);
    step(2'd3, 1'b0, 8'h00);
    check("R8 bad addr read", bus_rdata, 8'h00);
    // Constrained random traffic
    void'($urandom(32'd1234));
    for (int i = 0; i < 2000; i++) begin
      logic [1:0] a;
      logic [7:0] wd;
      int unsigned r;
      r  = $urandom % 16;
      a  = (r < 7) ? 2'd0 : (r < 15) ? 2'd1 : 2'(2 + ($urandom % 2));
      wd = 8'($urandom);
      if (a == 2'd1 && ($urandom % 3 == 0)) wd[3:0] = 4'd0;
      step(a, ($urandom % 4) != 0, wd);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule